// File: doc/BRIEF.md
# Sleep-Gated Tick Prescaler Controller

This block turns a free-running reference clock (nominally 25 MHz) into the count-enable tick that advances a PWM period counter. An 8-bit divisor register sets how many reference cycles make up one tick: a tick is issued every `divisor + 1` cycles. A full PWM period is therefore 4096 × (divisor + 1) reference cycles. The block keeps that 12-bit period counter itself and shows its value on a port for the channel comparators.

The divisor can only be changed while the device is asleep. A mode register holds the sleep flag in bit 4, and the block resets into sleep. The intended sequence is to enter sleep, rewrite the divisor and then clear sleep. Clearing sleep starts an oscillator-settling delay of a fixed number of reference cycles. Until that delay ends, the tick output and the period counter stay at zero. The registers are reached through a simple single-cycle byte write port, with a combinational read that follows the address.

Top module: `tick_prescaler_ctl`

## Requirements
- R1: After reset the mode register (address 0x00) reads 0x10 (asleep), the divisor (address 0xFE) reads 0x1E, and `tick_ready`, `cnt_tick` and `pwm_count` are all zero.
- R2: A write to address 0xFE while mode bit 4 is 1 stores the written byte, and the new value reads back from the following cycle.
- R3: A divisor write of a value below 3 while asleep is stored as 3. A write of exactly 3 is stored as 3.
- R4: A divisor write while mode bit 4 is 0 is ignored, and the divisor keeps its previous value.
- R5: All eight bits of the mode register are stored and read back as written. Only bit 4 (1 = asleep) changes behaviour.
- R6: A write that clears mode bit 4 makes `tick_ready` rise exactly WAKE_CYCLES clock cycles after the edge that performs the write. While `tick_ready` is low, `cnt_tick` is low and `pwm_count` is zero.
- R7: Once `tick_ready` is high, `cnt_tick` is a one-cycle pulse. The first pulse comes in the (divisor+1)-th cycle with `tick_ready` high, and the pulses then repeat every divisor+1 cycles.
- R8: `pwm_count` increases by one in the cycle after each tick. It wraps from 4095 to 0 on the 4096th tick.
- R9: A write that sets mode bit 4 forces `tick_ready` and `cnt_tick` low and `pwm_count` to zero in the next cycle. This holds even when `cnt_tick` is high in the cycle of the write.
- R10: Setting mode bit 4 at any point in the wake delay, including the edge that would end it, stops `tick_ready` from rising. A later wake restarts the full delay.
- R11: Writes to any address other than 0x00 and 0xFE change nothing. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one byte per cycle |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cnt_tick | output | 1 | One-cycle count-enable pulse for the PWM counter |
| tick_ready | output | 1 | High when awake and the wake delay has elapsed |
| pwm_count | output | PERIOD_W | PWM period counter, advanced by `cnt_tick` |

## Verification
Two events can fall in the same cycle. In the first, the sleep request arrives in a cycle where a tick is already being issued. In the second, the sleep request lands on the very edge where the wake delay would expire. The bench waits for the exact cycle of a predicted tick and writes sleep in that cycle. It expects the tick to be visible in that cycle, and it expects ready, tick and count all at zero from the next cycle, with no extra count. For the second case it wakes the block, then places the sleep write on the last delay cycle. It expects `tick_ready` to stay low throughout, and it expects a later wake to take the full delay again.

// File: rtl/pscl_pkg.sv
// Shared constants for the tick prescaler controller.
// Assumes byte-wide registers on an 8-bit address space.
package pscl_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int SLEEP_BIT = 4;
    localparam logic [ADDR_W-1:0] ADDR_MODE  = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_DIVSR = 8'hFE;
    localparam logic [DATA_W-1:0] MODE_RESET = 8'h10;
endpackage

// File: rtl/pscl_regs.sv
// Mode and divisor registers with a combinational read mux.
// The divisor is writable only while the stored sleep flag is set, and
// values under PRESC_MIN are raised to PRESC_MIN. The next sleep value is
// exported so that downstream timing can act on the same edge as the write.
module pscl_regs
    import pscl_pkg::*;
#(
    parameter int                PRESC_MIN   = 3,
    parameter logic [DATA_W-1:0] PRESC_RESET = 8'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] presc_q,
    output logic              sleep_nxt,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] FLOOR = DATA_W'(PRESC_MIN);

    logic mode_wr;
    logic divsr_wr;

    // Decode the write strobes; the divisor is gated by the current sleep flag.
    always_comb begin
        mode_wr  = wr_en && (addr == ADDR_MODE);
        divsr_wr = wr_en && (addr == ADDR_DIVSR) && mode_q[SLEEP_BIT];
    end

    // Look-ahead of the sleep flag for same-edge reaction in the wake timer.
    always_comb begin
        sleep_nxt = mode_wr ? wr_data[SLEEP_BIT] : mode_q[SLEEP_BIT];
    end

    // Mode register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_RESET;
        else if (mode_wr) mode_q <= wr_data;
    end

    // Divisor storage with floor clamp.
    always_ff @(posedge clk) begin
        if (!rst_n)        presc_q <= PRESC_RESET;
        else if (divsr_wr) presc_q <= (wr_data < FLOOR) ? FLOOR : wr_data;
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        case (addr)
            ADDR_MODE:  rd_data = mode_q;
            ADDR_DIVSR: rd_data = presc_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pscl_wake.sv
// Oscillator-settling timer. Counts WAKE_CYCLES reference cycles after the
// sleep flag clears, then raises ready. Any sleep request clears it at once.
// Assumes WAKE_CYCLES >= 1.
module pscl_wake #(
    parameter int WAKE_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_q,
    input  logic sleep_nxt,
    output logic ready_q,
    output logic ready_nxt
);
    localparam int WCNT_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
    localparam logic [WCNT_W-1:0] LAST = WCNT_W'(WAKE_CYCLES - 1);

    logic [WCNT_W-1:0] wcnt_q;
    logic [WCNT_W-1:0] wcnt_nxt;

    // Next-state of the delay counter and ready flag; sleep has priority.
    always_comb begin
        ready_nxt = ready_q;
        wcnt_nxt  = wcnt_q;
        if (sleep_nxt) begin
            ready_nxt = 1'b0;
            wcnt_nxt  = '0;
        end else if (!ready_q && !sleep_q) begin
            if (wcnt_q == LAST) ready_nxt = 1'b1;
            else                wcnt_nxt  = wcnt_q + 1'b1;
        end
    end

    // State registers of the settling timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            wcnt_q  <= '0;
        end else begin
            ready_q <= ready_nxt;
            wcnt_q  <= wcnt_nxt;
        end
    end
endmodule

// File: rtl/pscl_divider.sv
// Reference-cycle divider and PWM period counter. Issues a tick every
// presc+1 cycles while running and counts ticks modulo 2**PERIOD_W.
// Assumes presc is constant while running (it only changes asleep).
module pscl_divider #(
    parameter int DIV_W    = 8,
    parameter int PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                keep,
    input  logic [DIV_W-1:0]    presc,
    output logic                tick,
    output logic [PERIOD_W-1:0] count
);
    logic [DIV_W-1:0] div_q;
    logic             run;

    // Tick fires on the terminal divider value; run needs ready now and next.
    always_comb begin
        tick = active && (div_q == presc);
        run  = active && keep;
    end

    // Divider and period counter; both held at zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            count <= '0;
        end else if (tick) begin
            div_q <= '0;
            count <= count + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_prescaler_ctl.sv
// Top level: sleep-gated prescaler producing the PWM count tick.
// Ties register file, wake timer and divider together; the divisor only
// changes while asleep, so the divider never sees a mid-run change.
module tick_prescaler_ctl
    import pscl_pkg::*;
#(
    parameter int                WAKE_CYCLES = 12500,
    parameter int                PRESC_MIN   = 3,
    parameter logic [DATA_W-1:0] PRESC_RESET = 8'h1E,
    parameter int                PERIOD_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                cnt_tick,
    output logic                tick_ready,
    output logic [PERIOD_W-1:0] pwm_count
);
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] presc_q;
    logic              sleep_q;
    logic              sleep_nxt;
    logic              ready_nxt;

    assign sleep_q = mode_q[SLEEP_BIT];

    pscl_regs #(
        .PRESC_MIN  (PRESC_MIN),
        .PRESC_RESET(PRESC_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wr_data  (reg_wdata),
        .mode_q   (mode_q),
        .presc_q  (presc_q),
        .sleep_nxt(sleep_nxt),
        .rd_data  (reg_rdata)
    );

    pscl_wake #(
        .WAKE_CYCLES(WAKE_CYCLES)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_q  (sleep_q),
        .sleep_nxt(sleep_nxt),
        .ready_q  (tick_ready),
        .ready_nxt(ready_nxt)
    );

    pscl_divider #(
        .DIV_W   (DATA_W),
        .PERIOD_W(PERIOD_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .active(tick_ready),
        .keep  (ready_nxt),
        .presc (presc_q),
        .tick  (cnt_tick),
        .count (pwm_count)
    );
endmodule

// File: rtl/tick_prescaler_ctl_chk.sv
// Property checker for the tick prescaler controller, bound to the top.
module tick_prescaler_ctl_chk #(
    parameter int PRESC_MIN = 3,
    parameter int PERIOD_W  = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [7:0]          reg_addr,
    input logic [7:0]          reg_wdata,
    input logic                cnt_tick,
    input logic                tick_ready,
    input logic [PERIOD_W-1:0] pwm_count,
    input logic [7:0]          presc_q,
    input logic                sleep_q
);
    assert_divsr_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'hFE && sleep_q && reg_wdata >= 8'(PRESC_MIN))
        |=> (presc_q == $past(reg_wdata)));

    assert_divsr_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        presc_q >= 8'(PRESC_MIN));

    assert_awake_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'hFE && !sleep_q) |=> $stable(presc_q));

    assert_asleep_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_q |-> !tick_ready);

    assert_held_while_unready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_ready |-> (!cnt_tick && pwm_count == '0));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ready && $past(tick_ready) && $past(cnt_tick))
        |-> (pwm_count == PERIOD_W'($past(pwm_count) + 1'b1)));

    assert_sleep_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h00 && reg_wdata[4])
        |=> (!tick_ready && !cnt_tick && pwm_count == '0));
endmodule

bind tick_prescaler_ctl tick_prescaler_ctl_chk #(
    .PRESC_MIN(PRESC_MIN),
    .PERIOD_W (PERIOD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_tick  (cnt_tick),
    .tick_ready(tick_ready),
    .pwm_count (pwm_count),
    .presc_q   (presc_q),
    .sleep_q   (sleep_q)
);

// File: tb/test_tick_prescaler_ctl.sv
// Scoreboard bench: driver tasks queue expected values tagged with a cycle
// number, and a monitor compares them at the falling edge of that cycle.
module test_tick_prescaler_ctl;
    localparam int W  = 20;
    localparam int K_RD = 0, K_RDY = 1, K_TCK = 2, K_CNT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        cnt_tick;
    logic        tick_ready;
    logic [11:0] pwm_count;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    at;
        int    kind;
        int    exp;
        string tag;
    } exp_t;
    exp_t sbq[$];

    tick_prescaler_ctl #(.WAKE_CYCLES(W)) i_tick_prescaler_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_tick(cnt_tick),
        .tick_ready(tick_ready), .pwm_count(pwm_count)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every expectation due in this cycle and compare.
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].at == cyc) begin
                int act;
                case (sbq[i].kind)
                    K_RD:    act = int'(reg_rdata);
                    K_RDY:   act = int'(tick_ready);
                    K_TCK:   act = int'(cnt_tick);
                    default: act = int'(pwm_count);
                endcase
                checks++;
                if (act != sbq[i].exp) begin
                    errors++;
                    $display("FAIL %s cycle %0d kind %0d actual %0h expected %0h",
                             sbq[i].tag, cyc, sbq[i].kind, act, sbq[i].exp);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic push(input int kind, input int at, input int exp, input string tag);
        exp_t e;
        e.at = at; e.kind = kind; e.exp = exp; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
        reg_addr = a;
        push(K_RD, cyc, exp, tag);
        step(1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, output int edge_cyc);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        edge_cyc = cyc + 1;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic push_quiet(input int from, input int upto, input string tag);
        for (int k = from; k <= upto; k++) begin
            push(K_RDY, k, 0, tag);
            push(K_TCK, k, 0, tag);
            push(K_CNT, k, 0, tag);
        end
    endtask

    initial begin
        int e0, e1, e2, e3, es, t1, tk, p;
        step(3);
        rst_n = 1'b1;
        // R1: reset state
        push(K_RDY, cyc, 0, "R1"); push(K_TCK, cyc, 0, "R1"); push(K_CNT, cyc, 0, "R1");
        rd_chk(8'h00, 8'h10, "R1");
        rd_chk(8'hFE, 8'h1E, "R1");
        // R11: unmapped address writes and reads
        wr(8'h05, 8'hAA, e0);
        rd_chk(8'h05, 0, "R11");
        rd_chk(8'hFD, 0, "R11");
        rd_chk(8'h00, 8'h10, "R11");
        rd_chk(8'hFE, 8'h1E, "R11");
        // R2: divisor write while asleep
        wr(8'hFE, 8'h07, e0);
        rd_chk(8'hFE, 8'h07, "R2");
        // R3: floor clamp and boundary
        wr(8'hFE, 8'h01, e0);
        rd_chk(8'hFE, 3, "R3");
        wr(8'hFE, 8'h00, e0);
        rd_chk(8'hFE, 3, "R3");
        wr(8'hFE, 8'h03, e0);
        rd_chk(8'hFE, 3, "R3");
        p = 3;
        // R5: full mode byte stored, still asleep
        wr(8'h00, 8'hFA, e0);
        rd_chk(8'h00, 8'hFA, "R5");
        push(K_RDY, cyc + 4, 0, "R5");
        step(6);
        // R6/R7: wake, delay, first ticks
        wr(8'h00, 8'h05, e0);
        push_quiet(e0, e0 + W - 1, "R6");
        push(K_RDY, e0 + W, 1, "R6");
        for (int k = 0; k < p; k++) push(K_TCK, e0 + W + k, 0, "R7");
        t1 = e0 + W + p;
        push(K_TCK, t1, 1, "R7");
        push(K_TCK, t1 + 1, 0, "R7");
        push(K_TCK, t1 + p + 1, 1, "R7");
        push(K_CNT, t1, 0, "R8");
        push(K_CNT, t1 + 1, 1, "R8");
        push(K_CNT, t1 + p + 2, 2, "R8");
        rd_chk(8'h00, 8'h05, "R5");
        // R4: divisor write while awake is ignored
        wr(8'hFE, 8'h50, e1);
        rd_chk(8'hFE, 3, "R4");
        // R8: mid count and wrap
        push(K_CNT, t1 + 2047 * (p + 1) + 1, 2048, "R8");
        push(K_CNT, t1 + 4094 * (p + 1) + 1, 4095, "R8");
        push(K_TCK, t1 + 4095 * (p + 1), 1, "R8");
        push(K_CNT, t1 + 4095 * (p + 1) + 1, 0, "R8");
        // R9: sleep written in the exact cycle of a tick
        tk = t1 + 4096 * (p + 1);
        while (cyc < tk) step(1);
        push(K_TCK, tk, 1, "R9");
        push(K_CNT, tk, 4096 % 4096, "R9");
        wr(8'h00, 8'h10, es);
        push_quiet(es, es + 2, "R9");
        step(3);
        // R10: sleep written on the last wake-delay cycle
        wr(8'h00, 8'h00, e1);
        push_quiet(e1, e1 + W + 3, "R10");
        while (cyc < e1 + W - 1) step(1);
        wr(8'h00, 8'h10, e2);
        step(W);
        wr(8'h00, 8'h00, e3);
        push(K_RDY, e3 + W - 1, 0, "R10");
        push(K_RDY, e3 + W, 1, "R10");
        step(W + 3);
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expectations never compared", sbq.size());
        end
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule